// File: doc/BRIEF.md
# Indirect Configuration and Port Access Window

This block gives a host processor a narrow register window into a downstream bus that has a configuration space and an I/O port space. The host first stores an address token in a pointer register. It then reads or writes one of two data windows. Each data access starts one downstream cycle at the stored token. The window used decides whether the cycle is a configuration cycle or an I/O port cycle. Byte and halfword host accesses are steered onto the right byte lanes by the low host address bits.

On the host side the block is a memory-mapped slave. A request is held until a one-cycle `h_ready` pulse, so the slave can add wait states. On the downstream side there is a request/response port. It carries the cycle type, the direction, the address, the byte enables and the write data. The host access stays stalled until the downstream side acknowledges.

The controller has three states. In `ST_IDLE` the block waits for a host request. The transition "launch" goes to `ST_ISSUE` for a data window. The transition "local" goes straight to `ST_DONE` for the pointer register or an unmapped offset. `ST_ISSUE` holds the downstream request. Its transition "ack" leads to `ST_DONE`. `ST_DONE` pulses `h_ready`, and its transition "retire" returns to `ST_IDLE`.

Top module: `icw_window`

## Requirements
- R1: After reset, `h_ready` and `d_req` are 0 and the pointer register reads as 0.
- R2: The pointer register is at offset 0x064. A word write stores all 32 bits. A read returns the stored value. The value is kept unchanged across any number of data-window accesses.
- R3: An access at offset 0x068 starts a downstream cycle with `d_io`=0 (configuration) and `d_we` equal to `h_we`. `d_addr` is the pointer register with bits 1:0 forced to 0. In that token, bus number is bits 23:16, device/function is bits 15:8 and register offset is bits 7:0.
- R4: An access at offset 0x06C starts a downstream cycle with `d_io`=1 (I/O port). `d_addr` is pointer bits 15:0, zero-extended.
- R5: The byte enables depend on `h_size`. Size 0 (byte) gives a one-hot enable at lane `h_addr[1:0]`. Size 1 (halfword) gives 4'b0011 when `h_addr[1]`=0 and 4'b1100 when it is 1. Sizes 2 and 3 (word) give 4'b1111.
- R6: Write data is taken from the low bits of `h_wdata`. It is shifted up onto the enabled lanes: by 8 times the byte lane for a byte, and by 0 or 16 bits for a halfword.
- R7: Read data comes from the enabled lanes of `d_rdata`, or of the pointer register for offset 0x064. It is shifted down to bit 0 and zero-extended.
- R8: `d_req` rises one cycle after the host request and stays high, with address and enables stable, until `d_ack`. `h_ready` is a single-cycle pulse in the cycle after the acknowledge. It is never high while `d_req` is high.
- R9: When a read is acknowledged with `d_err`=1, `h_rdata` is all ones whatever the access size.
- R10: An access to any other offset starts no downstream cycle. A read there returns 0, and a write leaves the pointer register unchanged. The access completes with `h_ready` in the next cycle.
- R11: A byte or halfword write to offset 0x064 updates only the pointer register lanes its byte enables select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host access request, held until h_ready |
| h_we | input | 1 | Host write (1) or read (0) |
| h_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | DATA_W | Host write data, right-aligned |
| h_ready | output | 1 | Access complete pulse |
| h_rdata | output | DATA_W | Read data, valid with h_ready |
| d_req | output | 1 | Downstream cycle request |
| d_io | output | 1 | 1 I/O port cycle, 0 configuration cycle |
| d_we | output | 1 | Downstream write |
| d_addr | output | DATA_W | Downstream address token |
| d_be | output | DATA_W/8 | Downstream byte enables |
| d_wdata | output | DATA_W | Lane-steered write data |
| d_ack | input | 1 | Downstream response |
| d_err | input | 1 | Downstream error, valid with d_ack |
| d_rdata | input | DATA_W | Downstream read data, valid with d_ack |

## Verification
Two things can share a cycle. One is the pointer register update and the data access that uses it: the bench writes the pointer and then issues a data access straight after completion. It then judges whether the downstream address already carries the new token. The other is the downstream acknowledge arriving in the same cycle that `d_req` first rises. This is judged by `h_ready` coming exactly one cycle later. A delayed acknowledge is also used, and the bench confirms that the request and address hold steady while the host stays stalled.

// File: rtl/icw_pkg.sv
package icw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } icw_state_e;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_PTR  = 2'd1,
        WIN_CFG  = 2'd2,
        WIN_IO   = 2'd3
    } icw_win_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/icw_decode.sv
module icw_decode
    import icw_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LW = 2,
    parameter logic [ADDR_W-1:0] PTR_OFS = 12'h064,
    parameter logic [ADDR_W-1:0] CFG_OFS = 12'h068,
    parameter logic [ADDR_W-1:0] IO_OFS  = 12'h06C
) (
    input  logic [ADDR_W-LW-1:0] word_addr,
    output icw_win_e             sel
);
    always_comb begin
        if (word_addr == PTR_OFS[ADDR_W-1:LW])      sel = WIN_PTR;
        else if (word_addr == CFG_OFS[ADDR_W-1:LW]) sel = WIN_CFG;
        else if (word_addr == IO_OFS[ADDR_W-1:LW])  sel = WIN_IO;
        else                                        sel = WIN_NONE;
    end
endmodule

// File: rtl/icw_lane.sv
module icw_lane
    import icw_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LW = $clog2(LANES)
) (
    input  logic [1:0]        size,
    input  logic [LW-1:0]     lo,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] rdata_out
);
    logic [LW-1:0]     lane;
    logic [LW+2:0]     shamt;
    logic [DATA_W-1:0] mask;

    always_comb begin
        if (size == SZ_BYTE) begin
            lane = lo;
            be   = LANES'(1) << lane;
            mask = DATA_W'(8'hFF);
        end else if (size == SZ_HALF) begin
            lane = {lo[LW-1:1], 1'b0};
            be   = LANES'(2'b11) << lane;
            mask = DATA_W'(16'hFFFF);
        end else begin
            lane = '0;
            be   = '1;
            mask = '1;
        end
        shamt     = {lane, 3'b000};
        wdata_out = (wdata_in & mask) << shamt;
        rdata_out = (rdata_in >> shamt) & mask;
    end
endmodule

// File: rtl/icw_window.sv
module icw_window
    import icw_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int PORT_W = 16,
    parameter logic [ADDR_W-1:0] PTR_OFS = 12'h064,
    parameter logic [ADDR_W-1:0] CFG_OFS = 12'h068,
    parameter logic [ADDR_W-1:0] IO_OFS  = 12'h06C,
    localparam int LANES = DATA_W / 8,
    localparam int LW = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [1:0]        h_size,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_ready,
    output logic [DATA_W-1:0] h_rdata,
    output logic              d_req,
    output logic              d_io,
    output logic              d_we,
    output logic [DATA_W-1:0] d_addr,
    output logic [LANES-1:0]  d_be,
    output logic [DATA_W-1:0] d_wdata,
    input  logic              d_ack,
    input  logic              d_err,
    input  logic [DATA_W-1:0] d_rdata
);
    icw_state_e        state, nxt;
    icw_win_e          sel;
    logic [DATA_W-1:0] ptr_q;
    logic [DATA_W-1:0] rdata_q;
    logic [LANES-1:0]  be_c;
    logic [DATA_W-1:0] wsh_c;
    logic [DATA_W-1:0] ext_c;
    logic [DATA_W-1:0] ext_src;
    logic [DATA_W-1:0] cfg_tok;
    logic [DATA_W-1:0] io_tok;

    icw_decode #(
        .ADDR_W(ADDR_W), .LW(LW),
        .PTR_OFS(PTR_OFS), .CFG_OFS(CFG_OFS), .IO_OFS(IO_OFS)
    ) u_dec (
        .word_addr(h_addr[ADDR_W-1:LW]),
        .sel      (sel)
    );

    // Read source: downstream data while a cycle is open, pointer otherwise.
    assign ext_src = (state == ST_ISSUE) ? d_rdata : ptr_q;

    icw_lane #(.DATA_W(DATA_W)) u_lane (
        .size     (h_size),
        .lo       (h_addr[LW-1:0]),
        .wdata_in (h_wdata),
        .rdata_in (ext_src),
        .be       (be_c),
        .wdata_out(wsh_c),
        .rdata_out(ext_c)
    );

    assign cfg_tok = {ptr_q[DATA_W-1:2], 2'b00};
    assign io_tok  = DATA_W'(ptr_q[PORT_W-1:0]);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // Next state: launch / local / ack / retire
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (h_req) begin
                    if (sel == WIN_CFG || sel == WIN_IO) nxt = ST_ISSUE;
                    else                                 nxt = ST_DONE;
                end
            end
            ST_ISSUE: if (d_ack) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        d_req   = (state == ST_ISSUE);
        h_ready = (state == ST_DONE);
        h_rdata = rdata_q;
    end

    // Datapath captures
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            rdata_q <= '0;
            d_io    <= 1'b0;
            d_we    <= 1'b0;
            d_addr  <= '0;
            d_be    <= '0;
            d_wdata <= '0;
        end else begin
            if (state == ST_IDLE && h_req) begin
                unique case (sel)
                    WIN_CFG, WIN_IO: begin
                        d_io    <= (sel == WIN_IO);
                        d_we    <= h_we;
                        d_addr  <= (sel == WIN_IO) ? io_tok : cfg_tok;
                        d_be    <= be_c;
                        d_wdata <= wsh_c;
                    end
                    WIN_PTR: begin
                        if (h_we) begin
                            for (int i = 0; i < LANES; i++)
                                if (be_c[i]) ptr_q[8*i +: 8] <= wsh_c[8*i +: 8];
                        end
                        rdata_q <= ext_c;
                    end
                    default: rdata_q <= '0;
                endcase
            end
            if (state == ST_ISSUE && d_ack)
                rdata_q <= d_err ? '1 : ext_c;
        end
    end
endmodule

// File: rtl/icw_window_chk.sv
module icw_window_chk #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst,
    input logic              h_ready,
    input logic [DATA_W-1:0] h_rdata,
    input logic              d_req,
    input logic              d_we,
    input logic              d_ack,
    input logic              d_err,
    input logic [DATA_W-1:0] d_addr,
    input logic [LANES-1:0]  d_be
);
    // R8: request, address and enables hold until acknowledged
    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        d_req && !d_ack |=> d_req && $stable(d_addr) && $stable(d_be));

    // R8: completion follows the acknowledge by one cycle
    p_ready_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
        d_req && d_ack |=> h_ready && !d_req);

    // R8: completion is a single-cycle pulse
    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        h_ready |=> !h_ready);

    // R8: never complete while a downstream cycle is open
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        d_req |-> !h_ready);

    // R5: a downstream cycle always enables at least one lane
    p_be_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        d_req |-> d_be != '0);

    // R9: errored reads return all ones
    p_err_ones_r9: assert property (@(posedge clk) disable iff (rst)
        d_req && d_ack && d_err && !d_we |=> h_rdata == '1);
endmodule

bind icw_window icw_window_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .h_ready(h_ready), .h_rdata(h_rdata),
    .d_req(d_req), .d_we(d_we), .d_ack(d_ack), .d_err(d_err),
    .d_addr(d_addr), .d_be(d_be)
);

// File: tb/icw_window_test.sv
module icw_window_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        h_req = 0, h_we = 0;
    logic [1:0]  h_size = 0;
    logic [11:0] h_addr = 0;
    logic [31:0] h_wdata = 0;
    logic        h_ready, d_req, d_io, d_we;
    logic [31:0] h_rdata, d_addr, d_wdata;
    logic [3:0]  d_be;
    logic        d_ack = 0, d_err = 0;
    logic [31:0] d_rdata = 0;

    int checks = 0, fails = 0, stall_bad = 0;

    always #10 clk = ~clk;

    icw_window uut (
        .clk(clk), .rst(rst), .h_req(h_req), .h_we(h_we), .h_size(h_size),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_ready(h_ready), .h_rdata(h_rdata),
        .d_req(d_req), .d_io(d_io), .d_we(d_we), .d_addr(d_addr), .d_be(d_be),
        .d_wdata(d_wdata), .d_ack(d_ack), .d_err(d_err), .d_rdata(d_rdata)
    );

    // Observed results of the last transfer
    logic [31:0] o_rd, o_da, o_dwd;
    logic [3:0]  o_be;
    logic        o_saw, o_io, o_dwe;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [1:0] sz, input logic [11:0] a,
                        input logic [31:0] wd, input int dly, input logic [31:0] rsp,
                        input logic er);
        @(negedge clk);
        h_req = 1; h_we = we; h_size = sz; h_addr = a; h_wdata = wd;
        o_saw = 0; o_rd = 'x;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            d_ack = 0; d_err = 0;
            if (h_ready) begin
                o_rd = h_rdata;
                break;
            end
            if (d_req && !o_saw) begin
                o_saw = 1; o_io = d_io; o_da = d_addr; o_be = d_be;
                o_dwd = d_wdata; o_dwe = d_we;
                for (int k = 0; k < dly; k++) begin
                    @(negedge clk);
                    if (!d_req || h_ready || d_addr != o_da || d_be != o_be) stall_bad++;
                end
                d_ack = 1; d_err = er; d_rdata = rsp;
            end
        end
        h_req = 0; d_ack = 0; d_err = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(h_ready == 0, "R1 h_ready", 32'(h_ready), 0);
        chk(d_req == 0, "R1 d_req", 32'(d_req), 0);
        xfer(0, 2, 12'h064, 0, 0, 0, 0);
        chk(o_rd == 0, "R1 pointer reset", o_rd, 0);
    endtask

    task automatic t_ptr();
        xfer(1, 2, 12'h064, 32'h00123A48, 0, 0, 0);
        chk(!o_saw, "R2 no downstream on pointer write", 32'(o_saw), 0);
        xfer(0, 2, 12'h064, 0, 0, 0, 0);
        chk(o_rd == 32'h00123A48, "R2 readback", o_rd, 32'h00123A48);
    endtask

    task automatic t_cfg();
        xfer(0, 2, 12'h068, 0, 0, 32'hDEADBEEF, 0);
        chk(o_saw && !o_io && !o_dwe, "R3 cfg read kind", {o_saw, o_io, o_dwe}, 3'b100);
        chk(o_da == 32'h00123A48, "R3 cfg token", o_da, 32'h00123A48);
        chk(o_be == 4'hF, "R5 word enables", 32'(o_be), 32'hF);
        chk(o_rd == 32'hDEADBEEF, "R7 word read", o_rd, 32'hDEADBEEF);
        xfer(0, 0, 12'h06A, 0, 0, 32'hAABBCCDD, 0);
        chk(o_be == 4'b0100, "R5 byte lane 2", 32'(o_be), 32'h4);
        chk(o_rd == 32'hBB, "R7 byte lane 2", o_rd, 32'hBB);
        xfer(0, 0, 12'h069, 0, 0, 32'hAABBCCDD, 0);
        chk(o_be == 4'b0010, "R5 byte lane 1", 32'(o_be), 32'h2);
        chk(o_rd == 32'hCC, "R7 byte lane 1", o_rd, 32'hCC);
        xfer(0, 1, 12'h06A, 0, 0, 32'hAABBCCDD, 0);
        chk(o_be == 4'b1100, "R5 upper half", 32'(o_be), 32'hC);
        chk(o_rd == 32'hAABB, "R7 upper half", o_rd, 32'hAABB);
        xfer(0, 1, 12'h068, 0, 0, 32'hAABBCCDD, 0);
        chk(o_be == 4'b0011, "R5 lower half", 32'(o_be), 32'h3);
        chk(o_rd == 32'hCCDD, "R7 lower half", o_rd, 32'hCCDD);
    endtask

    task automatic t_write_lanes();
        xfer(1, 1, 12'h06A, 32'hFFFF1234, 0, 0, 0);
        chk(o_dwe && o_be == 4'b1100, "R6 half write enables", {o_dwe, o_be}, 5'b11100);
        chk(o_dwd == 32'h12340000, "R6 half write data", o_dwd, 32'h12340000);
        xfer(1, 0, 12'h06B, 32'h0000005A, 0, 0, 0);
        chk(o_dwd == 32'h5A000000, "R6 byte write data", o_dwd, 32'h5A000000);
        xfer(0, 2, 12'h064, 0, 0, 0, 0);
        chk(o_rd == 32'h00123A48, "R2 pointer kept", o_rd, 32'h00123A48);
    endtask

    task automatic t_io_and_align();
        xfer(1, 2, 12'h064, 32'hABCD03F8, 0, 0, 0);
        xfer(1, 0, 12'h06C, 32'h000000A5, 0, 0, 0);
        chk(o_saw && o_io, "R4 io kind", {o_saw, o_io}, 2'b11);
        chk(o_da == 32'h000003F8, "R4 port address", o_da, 32'h000003F8);
        chk(o_be == 4'b0001 && o_dwd == 32'hA5, "R6 io byte lane 0", o_dwd, 32'hA5);
        xfer(1, 2, 12'h064, 32'h00123A4B, 0, 0, 0);
        xfer(0, 2, 12'h068, 0, 0, 32'h1, 0);
        chk(o_da == 32'h00123A48, "R3 token low bits cleared", o_da, 32'h00123A48);
    endtask

    task automatic t_stall();
        stall_bad = 0;
        xfer(0, 2, 12'h06C, 0, 4, 32'h0BADF00D, 0);
        chk(stall_bad == 0, "R8 hold during stall", stall_bad, 0);
        chk(o_rd == 32'h0BADF00D, "R8 data after stall", o_rd, 32'h0BADF00D);
    endtask

    task automatic t_err();
        xfer(0, 2, 12'h068, 0, 1, 32'h12345678, 1);
        chk(o_rd == 32'hFFFFFFFF, "R9 word error", o_rd, 32'hFFFFFFFF);
        xfer(0, 0, 12'h069, 0, 0, 32'h12345678, 1);
        chk(o_rd == 32'hFFFFFFFF, "R9 byte error", o_rd, 32'hFFFFFFFF);
    endtask

    task automatic t_unmapped();
        xfer(1, 2, 12'h070, 32'hFFFFFFFF, 0, 0, 0);
        chk(!o_saw, "R10 no cycle on unmapped write", 32'(o_saw), 0);
        xfer(0, 2, 12'h060, 0, 0, 32'h55555555, 0);
        chk(!o_saw && o_rd == 0, "R10 unmapped read", o_rd, 0);
        xfer(0, 2, 12'h064, 0, 0, 0, 0);
        chk(o_rd == 32'h00123A4B, "R10 pointer untouched", o_rd, 32'h00123A4B);
    endtask

    task automatic t_ptr_lanes();
        xfer(1, 0, 12'h065, 32'h00000077, 0, 0, 0);
        xfer(0, 2, 12'h064, 0, 0, 0, 0);
        chk(o_rd == 32'h0012774B, "R11 byte write to pointer", o_rd, 32'h0012774B);
        xfer(1, 1, 12'h066, 32'h00009876, 0, 0, 0);
        xfer(0, 0, 12'h066, 0, 0, 0, 0);
        chk(o_rd == 32'h76, "R11 half write then byte read", o_rd, 32'h76);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_ptr();
        t_cfg();
        t_write_lanes();
        t_io_and_align();
        t_stall();
        t_err();
        t_unmapped();
        t_ptr_lanes();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule